// File: doc/BRIEF.md
# Rotating Register With Copy Chain

This block holds two serial registers of equal width that advance together on one shift strobe. The first register (the source) moves its word one stage to the right on every strobe. Its lowest stage feeds the serial output. When recirculation is enabled, that same bit wraps back into the source's top stage, so the word rotates instead of draining away.

The serial output also feeds the top stage of the second register (the copy). After a full set of strobes with recirculation on, the source holds its starting word again and the copy holds a duplicate of it. With recirculation off, the source drains to zero and the word ends up only in the copy.

The source can be loaded in parallel, and the copy can be cleared. These controls let the block be primed before a transfer and emptied afterwards.

Top module: `rot_copy_chain`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears both the source and the copy register to zero.
- R2: On a strobe (`shift_en` high, `load_en` low), every source stage takes the value of the stage above it. Port bit W-1 is the top stage and bit 0 is the bottom stage. The top stage takes the feed bit.
- R3: With `recirc_en` high, the feed bit is the source's bit 0, so after WIDTH strobes the source again holds its starting word.
- R4: With `recirc_en` low, the feed bit is 0, so after WIDTH strobes the source is all zeros.
- R5: On each strobe with `clear_copy` low, the copy shifts right and its top bit (bit W-1) takes the source's bit 0 from before the strobe. After WIDTH strobes from an empty copy, the copy holds the source's starting word.
- R6: `ser_out` always equals bit 0 of the source register, so a word leaves least significant bit first.
- R7: With `shift_en`, `load_en` and `clear_copy` all low, both registers keep their values.
- R8: With `load_en` high, the source takes `load_word` at the edge. Any strobe in that cycle is cancelled for both registers, so the copy holds.
- R9: With `clear_copy` high, the copy becomes zero at the edge, whatever the strobe does. The source still shifts or loads as R2 and R8 say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Shift strobe for both registers |
| recirc_en | input | 1 | Wrap the source's bottom bit back into its top stage |
| load_en | input | 1 | Parallel load of the source; takes priority over the strobe |
| load_word | input | WIDTH | Word written into the source on a load |
| clear_copy | input | 1 | Zero the copy register |
| src_word | output | WIDTH | Source register contents, bit WIDTH-1 is the top stage |
| copy_word | output | WIDTH | Copy register contents, bit WIDTH-1 is the top stage |
| ser_out | output | 1 | Serial output, the source's bottom stage |

## Verification
The bench builds the block at the default WIDTH of 4. At that width all sixteen words can be loaded, and a full rotation or a full drain takes only four strobes. Random sequences therefore often include complete transfers, loads in the middle of a transfer, and clears that overlap strobes. Directed sequences cover the 1101 rotation, where source and copy both end at 1101. They also cover the drain, where the source ends at zero and the copy holds 1101.

// File: rtl/rot_copy_pkg.sv
package rot_copy_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } stage_op_e;

    // clear beats load, load beats shift
    function automatic stage_op_e pick_op(input logic clr, input logic ld, input logic sh);
        if (clr)     return OP_CLEAR;
        else if (ld) return OP_LOAD;
        else if (sh) return OP_SHIFT;
        else         return OP_HOLD;
    endfunction

endpackage

// File: rtl/rotate_feed_sel.sv
module rotate_feed_sel (
    input  logic recirc_i,
    input  logic tap_i,
    output logic feed_o
);
    always_comb begin
        feed_o = recirc_i ? tap_i : 1'b0;
    end
endmodule

// File: rtl/serial_word_reg.sv
module serial_word_reg
    import rot_copy_pkg::*;
#(
    parameter int WIDTH = 4   // at least 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_i,
    input  logic             load_i,
    input  logic             clear_i,
    input  logic [WIDTH-1:0] load_word_i,
    input  logic             ser_in_i,
    output logic [WIDTH-1:0] word_o
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } reg_state_t;

    reg_state_t st_d, st_q;
    stage_op_e  op_d;

    always_comb begin
        st_d = st_q;
        op_d = pick_op(clear_i, load_i, shift_i);
        unique case (op_d)
            OP_CLEAR: st_d.word = '0;
            OP_LOAD:  st_d.word = load_word_i;
            OP_SHIFT: st_d.word = {ser_in_i, st_q.word[TOP:1]};
            default:  st_d.word = st_q.word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word_o = st_q.word;

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> word_o == '0);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_i && !load_i && !clear_i) |=> $stable(word_o));

    // R8
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !clear_i) |=> word_o == $past(load_word_i));

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> word_o == '0);

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !load_i && !clear_i) |=>
            (word_o[TOP-1:0] == $past(word_o[TOP:1]) && word_o[TOP] == $past(ser_in_i)));

endmodule

// File: rtl/rot_copy_chain.sv
module rot_copy_chain #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             recirc_en,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_word,
    input  logic             clear_copy,
    output logic [WIDTH-1:0] src_word,
    output logic [WIDTH-1:0] copy_word,
    output logic             ser_out
);
    localparam int NREG = 2;
    localparam int TOP  = WIDTH - 1;

    logic             feed_bit;
    logic             sh_v   [NREG];
    logic             ld_v   [NREG];
    logic             clr_v  [NREG];
    logic             sin_v  [NREG];
    logic [WIDTH-1:0] lw_v   [NREG];
    logic [WIDTH-1:0] word_v [NREG];

    rotate_feed_sel i_feed (
        .recirc_i (recirc_en),
        .tap_i    (word_v[0][0]),
        .feed_o   (feed_bit)
    );

    // index 0 = source, index 1 = copy; a load cancels the strobe for both
    always_comb begin
        sh_v[0]  = shift_en;
        ld_v[0]  = load_en;
        clr_v[0] = 1'b0;
        sin_v[0] = feed_bit;
        lw_v[0]  = load_word;
        sh_v[1]  = shift_en & ~load_en;
        ld_v[1]  = 1'b0;
        clr_v[1] = clear_copy;
        sin_v[1] = word_v[0][0];
        lw_v[1]  = '0;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        serial_word_reg #(.WIDTH(WIDTH)) i_reg (
            .clk         (clk),
            .rst         (rst),
            .shift_i     (sh_v[g]),
            .load_i      (ld_v[g]),
            .clear_i     (clr_v[g]),
            .load_word_i (lw_v[g]),
            .ser_in_i    (sin_v[g]),
            .word_o      (word_v[g])
        );
    end

    assign src_word  = word_v[0];
    assign copy_word = word_v[1];
    assign ser_out   = word_v[0][0];

    // R5
    copy_top_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !load_en && !clear_copy) |=> copy_word[TOP] == $past(src_word[0]));

    // R3
    wrap_top_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !load_en && recirc_en) |=> src_word[TOP] == $past(src_word[0]));

    // R4
    drain_top_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !load_en && !recirc_en) |=> src_word[TOP] == 1'b0);

    // R8
    load_copy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && !clear_copy) |=> $stable(copy_word));

endmodule

// File: tb/test_rot_copy_chain.sv
`timescale 1ns/1ps
module test_rot_copy_chain;
    localparam int W = 4;
    localparam time CLK_P = 20ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shift_en = 1'b0, recirc_en = 1'b0, load_en = 1'b0, clear_copy = 1'b0;
    logic [W-1:0] load_word = '0;
    logic [W-1:0] src_word, copy_word;
    logic ser_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [W-1:0] m_src = '0, m_copy = '0;

    always #(CLK_P/2) clk = ~clk;

    rot_copy_chain #(.WIDTH(W)) i_rot_copy_chain (
        .clk(clk), .rst(rst), .shift_en(shift_en), .recirc_en(recirc_en),
        .load_en(load_en), .load_word(load_word), .clear_copy(clear_copy),
        .src_word(src_word), .copy_word(copy_word), .ser_out(ser_out)
    );

    function automatic logic [W-1:0] next_src(logic [W-1:0] s, logic sh, logic rc,
                                              logic ld, logic [W-1:0] dv);
        if (ld) return dv;
        if (sh) return {(rc ? s[0] : 1'b0), s[W-1:1]};
        return s;
    endfunction

    function automatic logic [W-1:0] next_copy(logic [W-1:0] c, logic [W-1:0] s,
                                               logic sh, logic ld, logic cl);
        if (cl) return '0;
        if (sh && !ld) return {s[0], c[W-1:1]};
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic sh, input logic rc, input logic ld,
                        input logic [W-1:0] dv, input logic cl, input string tag);
        logic [W-1:0] es, ec;
        shift_en = sh; recirc_en = rc; load_en = ld; load_word = dv; clear_copy = cl;
        es = next_src(m_src, sh, rc, ld, dv);
        ec = next_copy(m_copy, m_src, sh, ld, cl);
        @(posedge clk);
        @(negedge clk);
        m_src = es; m_copy = ec;
        check(src_word == es, {tag, " src"}, src_word, es);
        check(copy_word == ec, {tag, " copy"}, copy_word, ec);
        check(ser_out == es[0], "R6 ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, es[0]});
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        // R1: reset from dirty state
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b1, 4'b1011, 1'b0, "R8 load");
        step(1'b1, 1'b1, 1'b0, 4'b0000, 1'b0, "R3 shift");
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_src = '0; m_copy = '0;
        check(src_word == '0, "R1 src", src_word, '0);
        check(copy_word == '0, "R1 copy", copy_word, '0);

        // R3 / R5: rotate 1101 once around, copy duplicates it
        step(1'b0, 1'b0, 1'b1, 4'b1101, 1'b0, "R8 load");
        for (int i = 0; i < W; i++) step(1'b1, 1'b1, 1'b0, '0, 1'b0, "R3 rotate");
        check(src_word == 4'b1101, "R3 rotated back", src_word, 4'b1101);
        check(copy_word == 4'b1101, "R5 duplicated", copy_word, 4'b1101);

        // R7: hold
        step(1'b0, 1'b1, 1'b0, 4'b0110, 1'b0, "R7 hold");
        check(src_word == 4'b1101, "R7 src held", src_word, 4'b1101);

        // R9 then R4: clear copy, drain source into copy
        step(1'b1, 1'b0, 1'b0, '0, 1'b1, "R9 clear with shift");
        check(copy_word == '0, "R9 copy zero", copy_word, '0);
        step(1'b0, 1'b0, 1'b1, 4'b1101, 1'b0, "R8 reload");
        for (int i = 0; i < W; i++) step(1'b1, 1'b0, 1'b0, '0, 1'b0, "R4 drain");
        check(src_word == '0, "R4 drained", src_word, '0);
        check(copy_word == 4'b1101, "R5 moved", copy_word, 4'b1101);

        // R8: load and strobe together, copy holds
        step(1'b1, 1'b1, 1'b1, 4'b0011, 1'b0, "R8 load beats shift");
        check(copy_word == 4'b1101, "R8 copy held", copy_word, 4'b1101);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic sh, rc, ld, cl;
            logic [W-1:0] dv;
            string tag;
            sh = ($urandom_range(0, 3) != 0);
            rc = $urandom_range(0, 1);
            ld = ($urandom_range(0, 7) == 0);
            cl = ($urandom_range(0, 9) == 0);
            dv = W'($urandom);
            if (cl)      tag = "R9 rnd";
            else if (ld) tag = "R8 rnd";
            else if (sh) tag = rc ? "R3 rnd" : "R4 rnd";
            else         tag = "R7 rnd";
            step(sh, rc, ld, dv, cl, tag);
        end

        // R2: single strobe shape check
        step(1'b0, 1'b0, 1'b1, 4'b1000, 1'b1, "R8 load");
        step(1'b1, 1'b0, 1'b0, '0, 1'b0, "R2 one strobe");
        check(src_word == 4'b0100, "R2 moved one stage", src_word, 4'b0100);
        check(copy_word == 4'b0000, "R5 bottom bit zero", copy_word, 4'b0000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule